// File: doc/BRIEF.md
# Buffered Modulus Counter

This block is the time base of one timer channel. A counter steps on pulses from an external prescaler and runs from 1 up to an end value. In up mode it then restarts at 1. In up/down mode it turns at the end value and counts back down to 1 before the next period begins. The end value sits in an active register. The active register is fed from a shadow register that software may rewrite at any moment. The new value reaches the active register only when one period turns into the next, so a period already running always finishes with the end value it started with.

At every period boundary a single-clock load strobe comes out, aligned with the counter step. A per-channel block input can keep the active register unchanged at that boundary. A match flag shows whenever the counter equals the active end value.

Top module: `bufmod_counter`

## Requirements
- R1: After a synchronous reset the counter reads 1, the shadow and active end values are 0, and the match flag is low.
- R2: The counter and its direction state change only in clocks where `step_en` is high. In all other clocks `count` is held and `boundary` is low.
- R3: With `mode_sel` = 0 (up mode), each step adds 1 to the counter until it equals the active end value. The step after that returns the counter to 1, and `boundary` is high for exactly that one clock.
- R4: With `mode_sel` = 1 (up/down mode) and an end value M of 2 or more, the counter runs 1, 2, ..., M, M-1, ..., 2. The step that takes it from 2 to 1 is the period boundary and raises `boundary` for that clock.
- R5: At a boundary the active end value takes the shadow value. A write to the shadow register in the same clock as the boundary is included in the transfer. At no other time does the active value change.
- R6: When several shadow writes fall inside one period, only the last one before the boundary becomes the next end value.
- R7: When `upd_block` is high in the boundary clock, the active end value is kept, and the next period runs to the old value again.
- R8: `match` is high exactly while `count` equals the active end value.
- R9: While the active end value is 0 or 1, the counter stays at 1 and every step is a boundary. With a value of 0, `match` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | One-clock step pulse from the prescaler |
| mode_sel | input | 1 | 0 = up count, 1 = up/down count |
| shadow_wr | input | 1 | Write strobe for the shadow end value |
| shadow_data | input | W | Value written to the shadow register |
| upd_block | input | 1 | Blocks the shadow-to-active transfer at the boundary |
| count | output | W | Current counter value |
| boundary | output | 1 | Load strobe, high for the clock in which a period ends |
| match | output | 1 | Counter equals the active end value |

## Verification
A table of runs sweeps both counting modes across end values from 1 to 9 and prescaler ratios from 1 to 3. Each run starts with a shadow write in its first clock. Small values show whether the up/down turn and the floor are handled as separate steps or merged, and ratios above 1 show whether anything moves between enable pulses. Directed cases then cover the following: a write that lands in the boundary clock itself, three writes in one period (to show which one wins), a transfer blocked against one that is not, and the degenerate end values 0 and 1.

// File: rtl/bufmod_pkg.sv
package bufmod_pkg;

    typedef enum logic {
        CNT_UP     = 1'b0,
        CNT_UPDOWN = 1'b1
    } cnt_mode_e;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } cnt_phase_e;

    typedef struct packed {
        logic       restart;
        logic       inc;
        cnt_phase_e next_phase;
    } step_ctl_t;

    // at_end: count has reached the end value; near_floor: count <= 2
    function automatic step_ctl_t decide_step(cnt_mode_e mode, cnt_phase_e ph,
                                              logic at_end, logic near_floor);
        step_ctl_t c;
        c.restart    = 1'b0;
        c.inc        = 1'b0;
        c.next_phase = PH_RISE;
        if (mode == CNT_UP) begin
            if (at_end) c.restart = 1'b1;
            else        c.inc     = 1'b1;
        end else if (ph == PH_RISE && !at_end) begin
            c.inc = 1'b1;
        end else if (near_floor) begin
            c.restart = 1'b1;
        end else begin
            c.next_phase = PH_FALL;
        end
        return c;
    endfunction

endpackage

// File: rtl/bufmod_match_buffer.sv
module bufmod_match_buffer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    input  logic         blk,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] shadow_nx;

    // a write in the boundary clock is part of the transfer
    assign shadow_nx = wr ? wdata : shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active   <= '0;
        end else begin
            shadow_q <= shadow_nx;
            if (load && !blk) active <= shadow_nx;
        end
    end

    // R7
    blocked_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (load && blk) |=> $stable(active));
    // R5
    no_midcycle_load_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active));
    // R5
    same_clock_write_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !blk && wr) |=> (active == $past(wdata)));

endmodule

// File: rtl/bufmod_count_core.sv
module bufmod_count_core
    import bufmod_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] active,
    output logic [W-1:0] count,
    output logic         boundary,
    output logic         match
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    cnt_phase_e phase_q;
    step_ctl_t  ctl;

    always_comb begin
        ctl = decide_step(mode, phase_q, count >= active, count <= TWO);
    end

    assign boundary = step_en & ctl.restart;
    assign match    = (count == active);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= ONE;
            phase_q <= PH_RISE;
        end else if (step_en) begin
            phase_q <= ctl.next_phase;
            if (ctl.restart)  count <= ONE;
            else if (ctl.inc) count <= count + ONE;
            else              count <= count - ONE;
        end
    end

    // R2
    hold_between_steps_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(count));
    // R2
    strobe_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |-> step_en);
    // R3
    restart_at_one_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (count == ONE));
    // R3
    up_increment_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !boundary && mode == CNT_UP) |=> (count == $past(count) + ONE));
    // R9
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        count != '0);

endmodule

// File: rtl/bufmod_counter.sv
module bufmod_counter
    import bufmod_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic         mode_sel,
    input  logic         shadow_wr,
    input  logic [W-1:0] shadow_data,
    input  logic         upd_block,
    output logic [W-1:0] count,
    output logic         boundary,
    output logic         match
);
    logic [W-1:0] active_val;
    cnt_mode_e    mode;

    assign mode = cnt_mode_e'(mode_sel);

    bufmod_match_buffer #(.W(W)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .wr     (shadow_wr),
        .wdata  (shadow_data),
        .load   (boundary),
        .blk    (upd_block),
        .active (active_val)
    );

    bufmod_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .mode     (mode),
        .active   (active_val),
        .count    (count),
        .boundary (boundary),
        .match    (match)
    );

endmodule

// File: tb/bufmod_counter_tb_top.sv
`timescale 1ns/1ps
module bufmod_counter_tb_top;
    localparam int W = 16;
    localparam int NV = 7;
    // {mode, end value, prescaler ratio, steps}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 8'd5, 3'd1, 8'd14},
        {1'b0, 8'd3, 3'd2, 8'd12},
        {1'b1, 8'd4, 3'd1, 8'd16},
        {1'b1, 8'd6, 3'd3, 8'd20},
        {1'b1, 8'd2, 3'd1, 8'd8},
        {1'b0, 8'd1, 3'd1, 8'd4},
        {1'b1, 8'd9, 3'd2, 8'd30}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0, mode_sel = 1'b0, shadow_wr = 1'b0, upd_block = 1'b0;
    logic [W-1:0] shadow_data = '0;
    logic [W-1:0] count;
    logic boundary, match;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // expected state
    logic [W-1:0] m_cnt, m_act, m_shd;
    logic m_fall;

    always #2.5 clk = ~clk;

    bufmod_counter #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .step_en(step_en), .mode_sel(mode_sel),
        .shadow_wr(shadow_wr), .shadow_data(shadow_data), .upd_block(upd_block),
        .count(count), .boundary(boundary), .match(match)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                         input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_en = 1'b0; shadow_wr = 1'b0; upd_block = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 1; m_act = 0; m_shd = 0; m_fall = 1'b0;
        #1;
        check(count, 1, "R1", "count after reset");
        check(W'(match), 0, "R1", "match after reset");
    endtask

    task automatic tick(input logic st, input logic wr, input logic [W-1:0] d,
                        input logic blk, input logic md, input string tag);
        logic e_bnd;
        logic [W-1:0] n_cnt;
        logic n_fall;
        @(negedge clk);
        step_en = st; shadow_wr = wr; shadow_data = d; upd_block = blk; mode_sel = md;
        #1;
        check(W'(match), W'(m_cnt == m_act), "R8", "match");
        e_bnd = 1'b0; n_fall = 1'b0; n_cnt = m_cnt;
        if (!md) begin
            if (m_cnt >= m_act) begin e_bnd = 1'b1; n_cnt = 1; end
            else n_cnt = m_cnt + 1;
        end else if (!m_fall && m_cnt < m_act) begin
            n_cnt = m_cnt + 1;
        end else if (m_cnt <= 2) begin
            e_bnd = 1'b1; n_cnt = 1;
        end else begin
            n_cnt = m_cnt - 1; n_fall = 1'b1;
        end
        e_bnd = e_bnd & st;
        check(W'(boundary), W'(e_bnd), st ? tag : "R2", "boundary");
        if (wr) m_shd = d;
        if (e_bnd && !blk) m_act = m_shd;
        if (st) begin m_cnt = n_cnt; m_fall = n_fall; end
        @(posedge clk);
        #1;
        check(count, m_cnt, st ? tag : "R2", "count");
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9: end value 0 keeps the counter at 1, every step ends a period
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R9");
        check(W'(match), 0, "R9", "match with end 0");

        // table walk over modes, end values and prescaler ratios
        for (int r = 0; r < NV; r++) begin
            logic md;
            logic [W-1:0] ev;
            int ratio, steps, pc, done;
            string tg;
            md = VEC[r][19]; ev = W'(VEC[r][18:11]);
            ratio = int'(VEC[r][10:8]); steps = int'(VEC[r][7:0]);
            tg = md ? "R4" : "R3";
            pc = 0; done = 0;
            for (int first = 1; done < steps; first = 0) begin
                logic st;
                st = (pc == ratio - 1);
                tick(st, first[0], ev, 1'b0, md, tg);
                pc = st ? 0 : pc + 1;
                if (st) done++;
            end
        end

        // R5: write in the boundary clock takes effect at once
        do_reset();
        tick(1'b1, 1'b1, W'(4), 1'b0, 1'b0, "R5");
        for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R5");

        // R7: blocked transfer keeps the old end value for one more period
        do_reset();
        tick(1'b1, 1'b1, W'(4), 1'b0, 1'b0, "R7");
        tick(1'b1, 1'b1, W'(9), 1'b1, 1'b0, "R7");
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, '0, 1'b1, 1'b0, "R7");
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R7");
        check(count, 1, "R7", "restart at old end value");
        for (int i = 0; i < 9; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R7");
        check(count, 1, "R7", "period with released value");

        // R6: last of several writes in one period wins
        do_reset();
        tick(1'b1, 1'b1, W'(3), 1'b0, 1'b1, "R6");
        tick(1'b0, 1'b1, W'(7), 1'b0, 1'b1, "R6");
        tick(1'b0, 1'b1, W'(2), 1'b0, 1'b1, "R6");
        tick(1'b0, 1'b1, W'(5), 1'b0, 1'b1, "R6");
        for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b1, "R6");

        // R9: end value 1 holds at 1 with match high
        do_reset();
        tick(1'b1, 1'b1, W'(1), 1'b0, 1'b1, "R9");
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b1, "R9");
        check(W'(match), 1, "R9", "match with end 1");

        // R1: reset in mid-run
        tick(1'b1, 1'b1, W'(6), 1'b0, 1'b0, "R3");
        tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R3");
        tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R3");
        do_reset();
        tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R1");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule